// File: doc/BRIEF.md
# Tone Guard-Time Validator

This block turns a raw "tone pair present" flag, coming from a dual-tone detector, into a validated digit-present output. The output rises only after the flag has stayed high without a break for a preset qualification time. Once high, it falls only after the flag has stayed low for a preset release time. Short gaps inside a digit are therefore bridged, and short bursts that are not real digits are rejected. Both guard times are counted in ticks. A prescaler, cleared whenever no guard is being timed, divides the 4.194304 MHz system clock to produce those ticks.

With the default settings the clock is divided by 4096, giving a tick of about 0.977 ms, and each guard is 31 ticks, about 30 ms. A tone of 40 ms or more is then accepted and a burst of 20 ms or less is rejected. In the same way, a pause of 40 ms or more ends a digit and a pause of 20 ms or less does not. A powerdown input forces the block back to its idle state and holds the output low.

Top module: `tone_guard_validator`

## Requirements
- R1: After reset the output `dsOut` is low and the block is idle; while `estIn` is low in idle, `dsOut` stays low.
- R2: From idle, with `pdIn` low, `dsOut` goes high right after the clock edge that samples `estIn` high for the (PRESENT_TICKS*PRESCALE_DIV+1)-th consecutive time (13 with the bench settings 4 and 3).
- R3: A run of `estIn` high samples shorter than in R2 leaves `dsOut` low. A single low sample returns the block to idle with the present count cleared, so the next run is timed from zero.
- R4: While `dsOut` is high and `estIn` stays high with `pdIn` low, `dsOut` stays high.
- R5: While `dsOut` is high, `dsOut` goes low right after the clock edge that samples `estIn` low for the (ABSENT_TICKS*PRESCALE_DIV)-th consecutive time (8 with the bench settings 4 and 2).
- R6: A low run of `estIn` shorter than in R5 leaves `dsOut` high. A return of `estIn` high clears the absent count, so a later dropout is timed from zero.
- R7: A clock edge that samples `pdIn` high forces `dsOut` low and the block to idle, whatever `estIn` does. After `pdIn` returns low, qualification starts again from zero as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (4.194304 MHz nominal) |
| rst | input | 1 | Asynchronous reset, active high |
| pdIn | input | 1 | Powerdown, active high |
| estIn | input | 1 | Raw tone-present flag from the detector |
| dsOut | output | 1 | Validated digit-present output |

## Verification
The two functions that can fall in the same cycle are the end of a guard window and an input change that would cancel it. Examples are a tick that completes the present count on the very edge where `estIn` drops, or powerdown arriving on the edge where a guard would expire. The bench lines up runs of exactly one sample below and at each threshold, and drops or powers down on the boundary sample. It judges the result by `dsOut` right after that edge. The checker also counts consecutive high and low samples at the ports, and requires every rise and every non-powerdown fall of `dsOut` to follow a run at least as long as the threshold.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUAL  = 2'd1,
    ST_VALID = 2'd2
  } guardState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic preRun;   // advance the tick prescaler
    logic presInc;  // count one present tick
    logic presClr;  // clear present count
    logic absInc;   // count one absent tick
    logic absClr;   // clear absent count
  } guardStrobe_t;

endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import guard_pkg::*;
#(
  parameter int PRESCALE_DIV  = 4096,
  parameter int PRESENT_TICKS = 31,
  parameter int ABSENT_TICKS  = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  guardStrobe_t strobe,
  output logic         tick,
  output logic         presDone,
  output logic         absDone
);

  localparam int PRE_W  = (PRESCALE_DIV > 2) ? $clog2(PRESCALE_DIV) : 1;
  localparam int PRES_W = $clog2(PRESENT_TICKS + 1);
  localparam int ABS_W  = $clog2(ABSENT_TICKS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRESCALE_DIV - 1);
  localparam logic [PRES_W-1:0] PRES_LAST = PRES_W'(PRESENT_TICKS - 1);
  localparam logic [ABS_W-1:0]  ABS_LAST  = ABS_W'(ABSENT_TICKS - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [PRES_W-1:0] presCnt;
  logic [ABS_W-1:0]  absCnt;

  assign tick     = strobe.preRun && (preCnt == PRE_LAST);
  assign presDone = (presCnt == PRES_LAST);
  assign absDone  = (absCnt == ABS_LAST);

  // Prescaler: held at zero whenever no guard window is being timed
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 preCnt <= '0;
    else if (!strobe.preRun) preCnt <= '0;
    else if (tick)           preCnt <= '0;
    else                     preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 presCnt <= '0;
    else if (strobe.presClr) presCnt <= '0;
    else if (strobe.presInc) presCnt <= presCnt + 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                absCnt <= '0;
    else if (strobe.absClr) absCnt <= '0;
    else if (strobe.absInc) absCnt <= absCnt + 1'b1;
  end

endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         pdIn,
  input  logic         estIn,
  input  logic         tick,
  input  logic         presDone,
  input  logic         absDone,
  output guardStrobe_t strobe,
  output logic         dsOut
);

  guardState_t state, stateNext;

  logic inQual, inValid;
  assign inQual  = (state == ST_QUAL);
  assign inValid = (state == ST_VALID);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (!pdIn && estIn) stateNext = ST_QUAL;
      ST_QUAL: begin
        if (pdIn || !estIn)        stateNext = ST_IDLE;
        else if (tick && presDone) stateNext = ST_VALID;
      end
      ST_VALID: begin
        if (pdIn)                            stateNext = ST_IDLE;
        else if (!estIn && tick && absDone)  stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.preRun  = !pdIn && ((inQual && estIn) || (inValid && !estIn));
    strobe.presInc = !pdIn && inQual && estIn && tick;
    strobe.presClr = pdIn || !inQual || !estIn;
    strobe.absInc  = !pdIn && inValid && !estIn && tick;
    strobe.absClr  = pdIn || !inValid || estIn;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign dsOut = inValid;

endmodule

// File: rtl/tone_guard_validator.sv
module tone_guard_validator #(
  parameter int PRESCALE_DIV  = 4096,
  parameter int PRESENT_TICKS = 31,
  parameter int ABSENT_TICKS  = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic pdIn,
  input  logic estIn,
  output logic dsOut
);

  guard_pkg::guardStrobe_t strobe;
  logic tick, presDone, absDone;

  guard_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pdIn     (pdIn),
    .estIn    (estIn),
    .tick     (tick),
    .presDone (presDone),
    .absDone  (absDone),
    .strobe   (strobe),
    .dsOut    (dsOut)
  );

  guard_datapath #(
    .PRESCALE_DIV  (PRESCALE_DIV),
    .PRESENT_TICKS (PRESENT_TICKS),
    .ABSENT_TICKS  (ABSENT_TICKS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .tick     (tick),
    .presDone (presDone),
    .absDone  (absDone)
  );

endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int PRESCALE_DIV  = 4096,
  parameter int PRESENT_TICKS = 31,
  parameter int ABSENT_TICKS  = 31
) (
  input logic clk,
  input logic rst,
  input logic pdIn,
  input logic estIn,
  input logic dsOut
);

  localparam int HI_NEED = PRESENT_TICKS * PRESCALE_DIV + 1;
  localparam int LO_NEED = ABSENT_TICKS * PRESCALE_DIV;

  int unsigned hiRun, loRun;

  // Consecutive-sample counters seen at the ports
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hiRun <= 0;
      loRun <= 0;
    end else begin
      hiRun <= (estIn && !pdIn) ? ((hiRun < 32'hFFFF_FFF0) ? hiRun + 1 : hiRun) : 0;
      loRun <= (!estIn) ? ((loRun < 32'hFFFF_FFF0) ? loRun + 1 : loRun) : 0;
    end
  end

  a_r1_idle_stays_low: assert property (@(posedge clk) disable iff (rst)
    (!dsOut && !estIn) |=> !dsOut);

  a_r2_rise_after_full_window: assert property (@(posedge clk) disable iff (rst)
    $rose(dsOut) |-> (hiRun >= HI_NEED));

  a_r3_rise_needs_tone: assert property (@(posedge clk) disable iff (rst)
    $rose(dsOut) |-> ($past(estIn) && !$past(pdIn)));

  a_r4_hold_while_present: assert property (@(posedge clk) disable iff (rst)
    (dsOut && estIn && !pdIn) |=> dsOut);

  a_r5_fall_after_full_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(dsOut) && !$past(pdIn)) |-> (loRun >= LO_NEED));

  a_r6_fall_needs_absence: assert property (@(posedge clk) disable iff (rst)
    ($fell(dsOut) && !$past(pdIn)) |-> !$past(estIn));

  a_r7_powerdown_low: assert property (@(posedge clk) disable iff (rst)
    pdIn |=> !dsOut);

endmodule

bind tone_guard_validator guard_checker #(
  .PRESCALE_DIV  (PRESCALE_DIV),
  .PRESENT_TICKS (PRESENT_TICKS),
  .ABSENT_TICKS  (ABSENT_TICKS)
) u_guard_checker (
  .clk   (clk),
  .rst   (rst),
  .pdIn  (pdIn),
  .estIn (estIn),
  .dsOut (dsOut)
);

// File: tb/tone_guard_validator_bench.sv
module tone_guard_validator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int PRES = 3;   // rise on 13th high sample
  localparam int ABS  = 2;   // fall on 8th low sample
  localparam int NVEC = 17;

  // {estIn, pdIn, len[15:0], expected dsOut, req[3:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'd12, 1'b0, 4'd3}, // R3 one short of threshold
    {1'b0, 1'b0, 16'd2,  1'b0, 4'd3}, // R3 back to idle
    {1'b1, 1'b0, 16'd13, 1'b1, 4'd2}, // R2 exact threshold
    {1'b1, 1'b0, 16'd5,  1'b1, 4'd4}, // R4 held while present
    {1'b0, 1'b0, 16'd7,  1'b1, 4'd6}, // R6 dropout one short
    {1'b1, 1'b0, 16'd3,  1'b1, 4'd6}, // R6 tone returns
    {1'b0, 1'b0, 16'd7,  1'b1, 4'd6}, // R6 absent count restarted
    {1'b0, 1'b0, 16'd1,  1'b0, 4'd5}, // R5 eighth low sample ends digit
    {1'b1, 1'b0, 16'd10, 1'b0, 4'd3}, // R3 partial run
    {1'b0, 1'b0, 16'd1,  1'b0, 4'd3}, // R3 single drop clears count
    {1'b1, 1'b0, 16'd12, 1'b0, 4'd3}, // R3 timed from zero
    {1'b1, 1'b0, 16'd1,  1'b1, 4'd2}, // R2 thirteenth sample
    {1'b1, 1'b1, 16'd1,  1'b0, 4'd7}, // R7 powerdown forces low
    {1'b1, 1'b1, 16'd20, 1'b0, 4'd7}, // R7 tone ignored in powerdown
    {1'b1, 1'b0, 16'd12, 1'b0, 4'd7}, // R7 requalify from zero
    {1'b1, 1'b0, 16'd1,  1'b1, 4'd7}, // R7 requalified
    {1'b0, 1'b0, 16'd8,  1'b0, 4'd5}  // R5 full gap
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdIn = 1'b0;
  logic estIn = 1'b0;
  logic dsOut;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_guard_validator #(
    .PRESCALE_DIV  (DIV),
    .PRESENT_TICKS (PRES),
    .ABSENT_TICKS  (ABS)
  ) u_tone_guard_validator (
    .clk   (clk),
    .rst   (rst),
    .pdIn  (pdIn),
    .estIn (estIn),
    .dsOut (dsOut)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (dsOut !== exp) begin
      failures++;
      $display("FAIL %s dsOut actual=%b expected=%b at %0t", req, dsOut, exp, $time);
    end
  endtask

  task automatic drive(input logic e, input logic p, input int len);
    estIn = e;
    pdIn  = p;
    repeat (len) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 during reset");
    rst = 1'b0;
    drive(1'b0, 1'b0, 5);
    check(1'b0, "R1 idle after reset");

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][22], VEC[i][21], int'(VEC[i][20:5]));
      check(VEC[i][4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // Directed: reset while valid, tone kept high (R1, R2)
    drive(1'b1, 1'b0, 13);
    check(1'b1, "R2 valid before reset");
    rst = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 reset clears output");
    rst = 1'b0;
    drive(1'b1, 1'b0, 12);
    check(1'b0, "R2 requalify short after reset");
    drive(1'b1, 1'b0, 1);
    check(1'b1, "R2 requalified after reset");

    // Directed: powerdown on the sample that would end the gap (R7)
    drive(1'b0, 1'b0, 7);
    check(1'b1, "R6 gap one short");
    drive(1'b0, 1'b1, 1);
    check(1'b0, "R7 powerdown at gap boundary");

    // Directed: drop on the sample that would complete qualification (R3)
    drive(1'b1, 1'b0, 12);
    drive(1'b0, 1'b0, 1);
    check(1'b0, "R3 drop at qualify boundary");
    drive(1'b0, 1'b0, 20);
    check(1'b0, "R1 idle stays low");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule